// File: doc/BRIEF.md
# Bus Clock Startup Sequencer

This block produces the bus clock enable for a chip's CPU and peripherals, and it controls how those clocks start after a power-on or low-voltage reset. It runs on one fast system clock. Two single-cycle strobe inputs mark the edges of the two possible source clocks: the crystal oscillator and the PLL output. The block picks one of the two strobes and divides it by four. Each bus clock edge then appears as a one-cycle enable, together with the current divider phase.

A power-on event or a low-voltage event starts the startup sequence. While the sequence runs, the divider is parked at phase zero and no bus enables come out. The source is forced to the oscillator, and the reset pin is pulled low. The sequence counts a fixed number of oscillator strobes: 4096 by default. When that count completes, the pin is released and the bus clocks start from a known phase. A new event during the count starts it again from zero.

A two-bit cause field records whether the most recent sequence came from a power-on or a low-voltage event. Firmware clears a bit of the field by writing one to it.

Top module: `busclk_seq`

## Requirements
- R1: `bus_en` pulses for one cycle, in the cycle after every fourth selected-source strobe. The selected source is the PLL strobe when the registered select is 1, and the oscillator strobe when it is 0.
- R2: `src_sel` takes effect through a one-cycle register. That register is forced to 0 (oscillator) in an event cycle and in every cycle of the sequence, so the first cycle after release still divides the oscillator strobe.
- R3: A cycle with `por_evt` or `lvi_evt` high is followed by a cycle with `rst_pull_low`=1, `bus_en`=0 and `bus_phase`=0.
- R4: The sequence lasts exactly TIMEOUT (4096) oscillator strobes, and PLL strobes do not advance it. `rst_pull_low` falls in the cycle after the edge that counts the last strobe.
- R5: An event that arrives while the sequence is running restarts the strobe count from zero.
- R6: `bus_phase` stays 0 throughout the sequence. After release, it counts selected strobes modulo four, and `bus_en` follows the step from 3 to 0.
- R7: `rst_src` bit 0 means power-on and bit 1 means low-voltage. An event overwrites the field with {lvi_evt, por_evt}. A cycle with `stat_wr`=1 clears each bit whose `stat_wdata` bit is 1. An event in the same cycle takes priority over the write.
- R8: While `rst_n` is low, the block is in the sequence with a zero count: `rst_pull_low`=1, `bus_en`=0, `bus_phase`=0, `rst_src`=2'b01, and the oscillator is selected. The count starts at the first edge after `rst_n` rises.
- R9: `rst_pull_low`=1 means the open-drain pin is pulled low. A value of 0 means the pin is released to high impedance. The pin is never driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle strobe per oscillator clock edge |
| pll_tick | input | 1 | One-cycle strobe per PLL clock edge |
| src_sel | input | 1 | Source request: 1 selects the PLL, 0 the oscillator |
| por_evt | input | 1 | Power-on reset event pulse |
| lvi_evt | input | 1 | Low-voltage reset event pulse |
| stat_wr | input | 1 | Write strobe for the cause field |
| stat_wdata | input | 2 | Write-one-to-clear mask for the cause field |
| bus_en | output | 1 | One-cycle enable per bus clock edge |
| bus_phase | output | 2 | Current divider phase |
| rst_pull_low | output | 1 | Open-drain pull-down enable for the reset pin |
| rst_src | output | 2 | Cause of the last sequence: bit 1 low-voltage, bit 0 power-on |

## Verification
Every output is registered, so a stimulus at one edge shows up at the ports in the following cycle. An event therefore parks the outputs, and sets the cause field, one cycle later. The pin releases one cycle after the edge that counts the 4096th oscillator strobe. A bus enable follows its fourth strobe by one cycle. A change of `src_sel` alters the strobe that is counted one cycle after it is sampled.

The bench drives its inputs on falling edges and advances a behavioural model on rising edges. It compares every output on the next falling edge, which is where each of these results is due. Directed checks add further counts on top of this comparison: oscillator strobes counted while the pin is held, cycles between enables for each source, and the cause field after writes and after writes that collide with events.

// File: rtl/busclk_pkg.sv
package busclk_pkg;

  typedef enum logic {
    SEQ_RUN  = 1'b0,
    SEQ_HOLD = 1'b1
  } seq_state_t;

  typedef struct packed {
    logic lvi;
    logic por;
  } rst_cause_t;

  function automatic rst_cause_t cause_of(input logic por, input logic lvi);
    rst_cause_t c;
    c.lvi = lvi;
    c.por = por;
    return c;
  endfunction

endpackage

// File: rtl/busclk_timeout.sv
module busclk_timeout
  import busclk_pkg::*;
#(
  parameter int TIMEOUT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic restart,
  output logic hold
);

  localparam int CNT_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

  seq_state_t       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // next state
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (restart) begin
      st_d   = SEQ_HOLD;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if ((st_q == SEQ_HOLD) && osc_tick) begin
      cnt_en = 1'b1;
      if (cnt_q == LAST) begin
        st_d  = SEQ_RUN;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_HOLD;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign hold = (st_q == SEQ_HOLD);

endmodule

// File: rtl/busclk_srcsel.sv
module busclk_srcsel (
  input  logic clk,
  input  logic rst_n,
  input  logic force_osc,
  input  logic src_sel,
  input  logic osc_tick,
  input  logic pll_tick,
  output logic sel_tick
);

  logic sel_q, sel_d;

  // next state: the PLL can only be chosen outside the sequence
  always_comb begin
    sel_d = force_osc ? 1'b0 : src_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
    end
  end

  assign sel_tick = sel_q ? pll_tick : osc_tick;

endmodule

// File: rtl/busclk_div.sv
module busclk_div #(
  parameter  int DIV_RATIO = 4,
  localparam int PH_W      = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            park,
  input  logic            tick,
  output logic [PH_W-1:0] phase,
  output logic            edge_en
);

  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV_RATIO - 1);

  logic [PH_W-1:0] ph_q, ph_d;
  logic            en_q, en_d;
  logic            wrap;

  always_comb begin
    wrap = tick && (ph_q == PH_LAST);
    if (park) begin
      ph_d = '0;
      en_d = 1'b0;
    end else begin
      en_d = wrap;
      if (wrap) begin
        ph_d = '0;
      end else if (tick) begin
        ph_d = ph_q + 1'b1;
      end else begin
        ph_d = ph_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
      en_q <= 1'b0;
    end else begin
      ph_q <= ph_d;
      en_q <= en_d;
    end
  end

  assign phase   = ph_q;
  assign edge_en = en_q;

endmodule

// File: rtl/busclk_cause.sv
module busclk_cause
  import busclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_evt,
  input  logic       lvi_evt,
  input  logic       wr,
  input  logic [1:0] wdata,
  output logic [1:0] cause
);

  rst_cause_t c_q, c_d;
  logic       c_en;

  always_comb begin
    c_d  = c_q;
    c_en = 1'b0;
    if (por_evt || lvi_evt) begin
      c_d  = cause_of(por_evt, lvi_evt);
      c_en = 1'b1;
    end else if (wr) begin
      c_d  = c_q & ~rst_cause_t'(wdata);
      c_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q <= cause_of(1'b1, 1'b0);
    end else if (c_en) begin
      c_q <= c_d;
    end
  end

  assign cause = c_q;

endmodule

// File: rtl/busclk_seq.sv
module busclk_seq #(
  parameter  int TIMEOUT   = 4096,
  parameter  int DIV_RATIO = 4,
  localparam int PH_W      = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            osc_tick,
  input  logic            pll_tick,
  input  logic            src_sel,
  input  logic            por_evt,
  input  logic            lvi_evt,
  input  logic            stat_wr,
  input  logic [1:0]      stat_wdata,
  output logic            bus_en,
  output logic [PH_W-1:0] bus_phase,
  output logic            rst_pull_low,
  output logic [1:0]      rst_src
);

  logic any_evt;
  logic hold;
  logic park;
  logic sel_tick;

  assign any_evt = por_evt | lvi_evt;
  assign park    = hold | any_evt;

  busclk_timeout #(
    .TIMEOUT (TIMEOUT)
  ) u_timeout (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_tick (osc_tick),
    .restart  (any_evt),
    .hold     (hold)
  );

  busclk_srcsel u_srcsel (
    .clk       (clk),
    .rst_n     (rst_n),
    .force_osc (park),
    .src_sel   (src_sel),
    .osc_tick  (osc_tick),
    .pll_tick  (pll_tick),
    .sel_tick  (sel_tick)
  );

  busclk_div #(
    .DIV_RATIO (DIV_RATIO)
  ) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .park    (park),
    .tick    (sel_tick),
    .phase   (bus_phase),
    .edge_en (bus_en)
  );

  busclk_cause u_cause (
    .clk     (clk),
    .rst_n   (rst_n),
    .por_evt (por_evt),
    .lvi_evt (lvi_evt),
    .wr      (stat_wr),
    .wdata   (stat_wdata),
    .cause   (rst_src)
  );

  // R9: open-drain pull-down, asserted only while holding
  assign rst_pull_low = hold;

endmodule

// File: rtl/busclk_seq_chk.sv
module busclk_seq_chk #(
  parameter  int DIV_RATIO = 4,
  localparam int PH_W      = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            osc_tick,
  input logic            por_evt,
  input logic            lvi_evt,
  input logic            stat_wr,
  input logic [1:0]      stat_wdata,
  input logic            bus_en,
  input logic [PH_W-1:0] bus_phase,
  input logic            rst_pull_low,
  input logic [1:0]      rst_src
);

  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV_RATIO - 1);

  // R1
  edge_after_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |-> (bus_phase == '0) && ($past(bus_phase) == PH_LAST));

  // R3
  event_parks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (por_evt || lvi_evt) |=> rst_pull_low && !bus_en && (bus_phase == '0));

  // R4
  release_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_pull_low) |-> $past(osc_tick) && !$past(por_evt || lvi_evt));

  // R5
  restart_keeps_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_pull_low && (por_evt || lvi_evt)) |=> rst_pull_low);

  // R6
  parked_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pull_low |-> (bus_phase == '0) && !bus_en);

  // R7
  cause_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (por_evt || lvi_evt) |=> (rst_src == $past({lvi_evt, por_evt})));

  // R7
  cause_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !por_evt && !lvi_evt) |=> ((rst_src & $past(stat_wdata)) == 2'b00));

endmodule

bind busclk_seq busclk_seq_chk #(
  .DIV_RATIO (DIV_RATIO)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .osc_tick     (osc_tick),
  .por_evt      (por_evt),
  .lvi_evt      (lvi_evt),
  .stat_wr      (stat_wr),
  .stat_wdata   (stat_wdata),
  .bus_en       (bus_en),
  .bus_phase    (bus_phase),
  .rst_pull_low (rst_pull_low),
  .rst_src      (rst_src)
);

// File: tb/busclk_seq_bench.sv
module busclk_seq_bench;

  localparam int TIMEOUT = 4096;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       osc_tick;
  logic       pll_tick;
  logic       src_sel;
  logic       por_evt;
  logic       lvi_evt;
  logic       stat_wr;
  logic [1:0] stat_wdata;
  logic       bus_en;
  logic [1:0] bus_phase;
  logic       rst_pull_low;
  logic [1:0] rst_src;

  int nchecks = 0;
  int nerr    = 0;
  bit done    = 1'b0;
  int tick_ctr = 0;

  always #2 clk = ~clk;

  busclk_seq u_busclk_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .osc_tick     (osc_tick),
    .pll_tick     (pll_tick),
    .src_sel      (src_sel),
    .por_evt      (por_evt),
    .lvi_evt      (lvi_evt),
    .stat_wr      (stat_wr),
    .stat_wdata   (stat_wdata),
    .bus_en       (bus_en),
    .bus_phase    (bus_phase),
    .rst_pull_low (rst_pull_low),
    .rst_src      (rst_src)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchecks++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // oscillator strobe every second cycle, PLL strobe every cycle
  always @(negedge clk) begin
    tick_ctr <= tick_ctr + 1;
    osc_tick <= tick_ctr[0];
  end

  // behavioural reference
  bit m_hold, m_sel, m_en;
  int m_cnt, m_ph;
  bit [1:0] m_stat;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hold = 1'b1; m_cnt = 0; m_sel = 1'b0; m_ph = 0; m_en = 1'b0; m_stat = 2'b01;
    end else begin
      bit evt, t, blk;
      evt = por_evt || lvi_evt;
      t   = m_sel ? pll_tick : osc_tick;
      blk = m_hold || evt;
      m_en = !blk && t && (m_ph == 3);
      if (blk) m_ph = 0;
      else if (t) m_ph = (m_ph + 1) % 4;
      m_sel = blk ? 1'b0 : src_sel;
      if (evt) begin
        m_hold = 1'b1; m_cnt = 0;
      end else if (m_hold && osc_tick) begin
        if (m_cnt == TIMEOUT - 1) begin m_hold = 1'b0; m_cnt = 0; end
        else m_cnt++;
      end
      if (evt) m_stat = {lvi_evt, por_evt};
      else if (stat_wr) m_stat = m_stat & ~stat_wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4", "rst_pull_low vs model", int'(rst_pull_low), int'(m_hold));
      chk("R1", "bus_en vs model", int'(bus_en), int'(m_en));
      chk("R6", "bus_phase vs model", int'(bus_phase), m_ph);
      chk("R7", "rst_src vs model", int'(rst_src), int'(m_stat));
    end
  end

  // count oscillator strobes while the pin is held
  int tally = 0;
  bit prev_pull = 1'b1;
  always @(posedge clk) begin
    if (!rst_n || por_evt || lvi_evt) tally <= 0;
    else if (rst_pull_low && osc_tick) tally <= tally + 1;
  end
  always @(negedge clk) begin
    if (rst_n && prev_pull && !rst_pull_low)
      chk("R4", "oscillator strobes while held", tally, TIMEOUT);
    prev_pull <= rst_pull_low;
  end

  task automatic wait_release();
    do @(negedge clk); while (rst_pull_low);
  endtask

  task automatic bus_gap(output int gap);
    do @(negedge clk); while (!bus_en);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!bus_en);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nerr++;
      $display("FAIL R4 watchdog: actual run still active expected completion");
      finish_run();
    end
  end

  initial begin
    int gap, since;
    rst_n = 1'b0; pll_tick = 1'b1; src_sel = 1'b0; osc_tick = 1'b0;
    por_evt = 1'b0; lvi_evt = 1'b0; stat_wr = 1'b0; stat_wdata = 2'b00;
    repeat (4) @(negedge clk);
    // R8 reset state
    chk("R8", "pull low in reset", int'(rst_pull_low), 1);
    chk("R8", "bus_en in reset", int'(bus_en), 0);
    chk("R8", "phase in reset", int'(bus_phase), 0);
    chk("R8", "cause in reset", int'(rst_src), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8", "sequence active after reset", int'(rst_pull_low), 1);
    wait_release();
    chk("R9", "pin released after timeout", int'(rst_pull_low), 0);
    bus_gap(gap);
    chk("R1", "enable gap on oscillator", gap, 8);

    src_sel = 1'b1;
    repeat (3) @(negedge clk);
    bus_gap(gap);
    chk("R2", "enable gap on PLL", gap, 4);

    lvi_evt = 1'b1;
    @(negedge clk);
    lvi_evt = 1'b0;
    chk("R3", "pull low after event", int'(rst_pull_low), 1);
    chk("R3", "bus_en after event", int'(bus_en), 0);
    chk("R3", "phase after event", int'(bus_phase), 0);
    chk("R7", "cause after low-voltage", int'(rst_src), 2);

    repeat (1000) @(negedge clk);
    chk("R5", "still held before restart", int'(rst_pull_low), 1);
    por_evt = 1'b1;
    @(negedge clk);
    por_evt = 1'b0;
    since = 1;
    do begin @(negedge clk); since++; end while (rst_pull_low);
    chk("R5", "restart holds a full timeout", int'(since >= 2 * TIMEOUT - 2), 1);
    chk("R7", "cause after power-on", int'(rst_src), 1);

    stat_wr = 1'b1; stat_wdata = 2'b01;
    @(negedge clk);
    stat_wr = 1'b0; stat_wdata = 2'b00;
    chk("R7", "cause cleared by write", int'(rst_src), 0);
    chk("R7", "write leaves pin released", int'(rst_pull_low), 0);

    lvi_evt = 1'b1; stat_wr = 1'b1; stat_wdata = 2'b11;
    @(negedge clk);
    lvi_evt = 1'b0; stat_wr = 1'b0; stat_wdata = 2'b00;
    chk("R7", "event beats write", int'(rst_src), 2);
    wait_release();
    repeat (20) @(negedge clk);
    finish_run();
  end

endmodule